// File: doc/BRIEF.md
# Segmented Set-Before-First Mask Unit

The unit turns a source predicate mask into a mask that has a 1 in every position below the lowest 1 of the source. It scans the source from bit 0 up to bit XLEN-1. A second operand, the restart mask, can split the scan into segments. Wherever the restart mask holds a 1, a new segment begins: the unit starts setting result bits again from that position until it meets the next 1 in the source.

A flag marks the restart operand as absent, which is the zero-register case. When the flag is set, the scan starts in setting mode and runs as a single segment. When the flag is clear, the scan starts in setting mode only if bit 0 of the restart mask is 1.

The unit is a pure function of its operands. The result is registered, so each result appears exactly one cycle after its operands are presented. A new operation can be accepted every cycle.

Top module: `sbf_mask_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low in the cycle after a cycle in which it was low. A new operation can be accepted on every cycle.
- R2: While `rst` is high at a rising clock edge, `out_valid` and `out_mask` both go to 0 at that edge.
- R3: With `restart_absent` = 1, result bit i is 1 exactly when source bits 0 through i are all 0. An all-zero source therefore gives an all-ones result.
- R4: With `restart_absent` = 1 and source bit 0 equal to 1, the result is all zeros.
- R5: With `restart_absent` = 0, the scan starts in setting mode only when restart bit 0 is 1. A restart mask of zero gives an all-zero result, whatever the source.
- R6: With `restart_absent` = 0, a restart bit of 1 at position i re-enters setting mode at i itself. Result bit i is then 1 if source bit i is 0. For example, restart 8'hC3 with source 8'h94 gives 8'h43.
- R7: No result bit is ever 1 where the source bit is 1. If the restart bit and the source bit are both 1 at the same position, that result bit is 0 and the scan continues in searching mode.
- R8: When `in_valid` is low, `out_mask` keeps its previous value.
- R9: XLEN is a parameter. Widths of 8, 32 and 64 give the same per-bit behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented this cycle |
| src_mask | input | XLEN | Source mask; its lowest 1 in each segment ends setting |
| restart_mask | input | XLEN | Restart mask; a 1 opens a new setting segment |
| restart_absent | input | 1 | 1 means no restart operand (single segment, starts setting) |
| out_valid | output | 1 | Result is valid this cycle |
| out_mask | output | XLEN | Registered result mask |

## Verification
Each result and its valid strobe are due at the first rising edge after the operands are presented. The bench drives its inputs at falling edges and compares at the falling edge that follows. It keeps operations back-to-back: at each falling edge it first checks the expected result of the previous operation, then drives the next one. A single misplaced register therefore shows up as a mismatch. The idle-cycle and reset checks look one falling edge after the stimulus, which is where the hold or the clear must already be visible.

// File: rtl/sbf_mask_unit.sv
module sbf_mask_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] src_mask,
  input  logic [XLEN-1:0] restart_mask,
  input  logic            restart_absent,
  output logic            out_valid,
  output logic [XLEN-1:0] out_mask
);

  // live[i]: setting mode survives position i (equals the result bit)
  logic [XLEN-1:0] live;
  logic [XLEN-1:0] rearm;

  assign rearm = restart_absent ? '0 : restart_mask;

  genvar i;
  generate
    for (i = 0; i < XLEN; i++) begin : g_scan
      if (i == 0) begin : g_first
        assign live[i] = ~src_mask[i] & (restart_absent | rearm[i]);
      end else begin : g_rest
        assign live[i] = ~src_mask[i] & (live[i-1] | rearm[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_mask <= live;
    end
  end

endmodule

// File: rtl/sbf_mask_unit_chk.sv
module sbf_mask_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [XLEN-1:0] src_mask,
  input logic [XLEN-1:0] restart_mask,
  input logic            restart_absent,
  input logic            out_valid,
  input logic [XLEN-1:0] out_mask
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R1
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && out_mask == '0)); // R2
  AST_EMPTY_SRC_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && restart_absent && src_mask == '0) |=> (out_mask == '1)); // R3
  AST_LSB_SRC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && restart_absent && src_mask[0]) |=> (out_mask == '0)); // R4
  AST_NO_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !restart_absent && restart_mask == '0) |=> (out_mask == '0)); // R5
  AST_NO_SRC_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_mask & $past(src_mask)) == '0)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_mask)); // R8

endmodule

bind sbf_mask_unit sbf_mask_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_sbf_mask_unit.sv
`timescale 1ns/1ps
module tb_sbf_mask_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       v8 = 1'b0, a8 = 1'b1;
  logic [7:0] s8 = '0, r8 = '0;
  logic       ov8;
  logic [7:0] om8;

  logic        vw = 1'b0, aw = 1'b1;
  logic [63:0] sw = '0, rw = '0;
  logic        ovw;
  logic [63:0] omw;

  sbf_mask_unit #(.XLEN(8)) dut (
    .clk(clk), .rst(rst), .in_valid(v8), .src_mask(s8), .restart_mask(r8),
    .restart_absent(a8), .out_valid(ov8), .out_mask(om8));

  sbf_mask_unit #(.XLEN(64)) dut_wide (
    .clk(clk), .rst(rst), .in_valid(vw), .src_mask(sw), .restart_mask(rw),
    .restart_absent(aw), .out_valid(ovw), .out_mask(omw));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Spec model: per-position mode walk over n bits
  function automatic logic [63:0] model(logic [63:0] s, logic [63:0] r, logic ab, int n);
    logic [63:0] res = '0;
    logic setting = ab ? 1'b1 : r[0];
    for (int k = 0; k < n; k++) begin
      if (!ab && r[k]) setting = 1'b1;
      if (setting) begin
        if (s[k]) setting = 1'b0;
        else res[k] = 1'b1;
      end
    end
    return res;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(logic [7:0] s, logic [7:0] r, logic ab);
    if (ab) return s[0] ? "R4" : "R3";
    if (r == 8'h00) return "R5";
    if ((s & r) != 8'h00) return "R7";
    return "R6";
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pe;
    logic pv;
    string pt;
    repeat (3) @(negedge clk);
    check("R2 reset valid", 64'(ov8), 64'h0);
    check("R2 reset mask", 64'(om8), 64'h0);
    rst = 1'b0;

    // explicit segmented example
    @(negedge clk);
    v8 = 1'b1; a8 = 1'b0; r8 = 8'hC3; s8 = 8'h94;
    @(negedge clk);
    v8 = 1'b0;
    check("R6 example", 64'(om8), 64'h43);
    check("R1 valid", 64'(ov8), 64'h1);
    @(negedge clk);
    check("R8 hold", 64'(om8), 64'h43);
    check("R1 idle", 64'(ov8), 64'h0);

    // exhaustive back-to-back sweep
    pv = 1'b0; pe = '0; pt = "";
    for (int ab = 1; ab >= 0; ab--) begin
      for (int r = 0; r < 256; r++) begin
        if (ab == 1 && r > 0) break;
        for (int s = 0; s < 256; s++) begin
          @(negedge clk);
          if (pv) begin
            check(pt, 64'(om8), 64'(pe));
            check("R1 pipelined valid", 64'(ov8), 64'h1);
          end
          v8 = 1'b1; a8 = ab[0]; r8 = r[7:0]; s8 = s[7:0];
          pe = model(64'(s), 64'(r), ab[0], 8)[7:0];
          pt = tag_of(s[7:0], r[7:0], ab[0]);
          pv = 1'b1;
        end
      end
    end
    @(negedge clk);
    v8 = 1'b0;
    check(pt, 64'(om8), 64'(pe));
    @(negedge clk);
    check("R8 hold after sweep", 64'(om8), 64'(pe));

    // wide instance, directed vectors
    for (int t = 0; t < 6; t++) begin
      logic [63:0] ws, wr;
      logic wa;
      case (t)
        0: begin ws = 64'h0; wr = 64'h0; wa = 1'b1; end
        1: begin ws = 64'h8000_0000_0000_0000; wr = 64'h0; wa = 1'b1; end
        2: begin ws = 64'h0000_0001_0000_0000; wr = 64'h0; wa = 1'b1; end
        3: begin ws = 64'h0100_0010_0000_0004; wr = 64'h0010_0000_8000_0001; wa = 1'b0; end
        4: begin ws = 64'hFFFF_0000_FFFF_0000; wr = 64'h0; wa = 1'b0; end
        default: begin ws = 64'h8421_8421_8421_8421; wr = 64'h4210_4210_4210_4211; wa = 1'b0; end
      endcase
      @(negedge clk);
      vw = 1'b1; sw = ws; rw = wr; aw = wa;
      @(negedge clk);
      vw = 1'b0;
      check("R9 wide", omw, model(ws, wr, wa, 64));
      check("R9 wide valid", 64'(ovw), 64'h1);
    end

    // reset with a result present
    rst = 1'b1;
    @(negedge clk);
    check("R2 mid reset mask", 64'(om8), 64'h0);
    check("R2 mid reset wide", omw, 64'h0);
    rst = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule